// File: doc/BRIEF.md
# Serial Configuration-ROM Read Responder

This block stands in for a small three-wire serial ROM of 64 sixteen-bit words, seen by software through one host-written access register. Software bit-bangs the serial protocol by writing four fields of that register: a select line, a serial clock, a data-in line and a read-only data-out line. Every host write that raises the clock bit while select is high moves the serial engine forward by one bit.

A transfer consists of a start bit, a two-bit command and a six-bit word address, all sent MSB first. Sixteen data bits then come back MSB first on the data-out bit, one per further clock rise. Only the read command is answered. Only the three words that carry the 48-bit station address are populated; all other content is absent. An unknown command or an unpopulated address raises a sticky error flag and drops the engine back to waiting for a start bit. The register readback is registered, so the result of a write is visible on the cycle after the write strobe.

Top module: `mw_rom_responder`

## Requirements
- R1: After reset the register reads 0x12 and the error flag is 0. Field positions: bit 0 data-in, bit 1 data-out, bit 2 serial clock, bit 3 select, bits 7:4 plain storage.
- R2: The engine advances only on a write whose clock bit is 1 when the previously written clock bit was 0, with select 1 in that write. Writing clock 1 again does not advance it.
- R3: A write with select 0 aborts any transfer in progress, returns the engine to waiting for a start bit, and reads back with data-in 0.
- R4: While waiting, rising clock edges with data-in 0 are ignored. The first edge with data-in 1 is the start bit.
- R5: Two command bits follow, MSB first. Only binary 10 (read) is accepted. Any other value sets the error flag and returns the engine to waiting.
- R6: Six address bits follow, MSB first. Word 0xA holds station bytes 5 (upper half) and 4, word 0xB holds bytes 3 and 2, and word 0xC holds bytes 1 and 0. Station byte n is station_addr[8n+7:8n]. Any other address sets the error flag and returns the engine to waiting.
- R7: Each following rising edge drives the next data bit onto data-out, MSB first, 16 in all. After the 16th bit the engine waits for a new start bit, and further edges leave data-out unchanged.
- R8: Data-out is read-only. Host writes update all other bits and keep the current data-out value.
- R9: The write that completes a valid address reads back with data-in 0, whatever data-in value it carried.
- R10: The error flag stays set until reset, across later successful reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write value |
| station_addr | input | 8*MAC_BYTES | Station address, byte n at bits 8n+7:8n |
| rd_data | output | REG_W | Registered register readback |
| err_flag | output | 1 | Sticky protocol error |

## Verification
The bench repeats clock-high writes inside a transfer. A design that advanced on the level instead of the edge would shift extra bits and return a wrong word. It forces data-out to the opposite value on low-clock writes during the data phase. Letting that bit become writable would corrupt the word as it is read back bit by bit. It aborts transfers halfway through the address, sends leading zero bits before the start bit, and issues illegal commands and unpopulated addresses before a clean read. A stale counter or a missed return to idle would misalign the next word or leave the error flag wrong. It also checks that data-in reads back clear after the address phase, and that the error flag survives later good reads.

// File: rtl/mw_rom_pkg.sv
package mw_rom_pkg;
  localparam int DI_BIT  = 0;
  localparam int DO_BIT  = 1;
  localparam int CLK_BIT = 2;
  localparam int SEL_BIT = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_ADR  = 2'd2,
    PH_DAT  = 2'd3
  } phase_t;
endpackage

// File: rtl/mw_word_lookup.sv
module mw_word_lookup #(
  parameter int MAC_BYTES = 6,
  parameter int ADDR_W    = 6,
  parameter int WORD_W    = 16,
  parameter logic [ADDR_W-1:0] BASE = 6'hA
) (
  input  logic [8*MAC_BYTES-1:0] station_addr,
  input  logic [ADDR_W-1:0]      addr,
  output logic                   hit,
  output logic [WORD_W-1:0]      word
);
  localparam int NW = MAC_BYTES / 2;

  logic [NW-1:0]     match;
  logic [WORD_W-1:0] slot [NW];

  for (genvar k = 0; k < NW; k++) begin : g_slot
    localparam int J = NW - 1 - k;
    assign match[k] = (addr == BASE + ADDR_W'(k));
    assign slot[k]  = {station_addr[8*(2*J+1) +: 8], station_addr[8*(2*J) +: 8]};
  end

  always_comb begin
    hit  = |match;
    word = '0;
    for (int k = 0; k < NW; k++)
      if (match[k]) word = word | slot[k];
  end
endmodule

// File: rtl/mw_serial_engine.sv
module mw_serial_engine
  import mw_rom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter int CMD_W  = 2,
  parameter logic [CMD_W-1:0] CMD_READ = 2'b10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              w_sel,
  input  logic              w_clk,
  input  logic              w_di,
  input  logic              rom_hit,
  input  logic [WORD_W-1:0] rom_word,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              do_load,
  output logic              do_val,
  output logic              di_clear,
  output logic              err
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [CMD_W-1:0]  cmd;
  logic [ADDR_W-1:0] adr;
  logic [WORD_W-1:0] sh;
  logic              prev_clk;
  logic              rise;
  logic              last;
  logic [CMD_W-1:0]  cmd_nx;

  assign rise     = wr_en && w_sel && w_clk && !prev_clk;
  assign last     = (cnt == CNT_W'(1));
  assign cmd_nx   = {cmd[CMD_W-2:0], w_di};
  assign rom_addr = {adr[ADDR_W-2:0], w_di};
  assign do_load  = rise && (phase == PH_DAT);
  assign do_val   = sh[WORD_W-1];
  assign di_clear = rise && (phase == PH_ADR) && last && rom_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      cmd      <= '0;
      adr      <= '0;
      sh       <= '0;
      prev_clk <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (wr_en) prev_clk <= w_clk;
      if (wr_en && !w_sel) begin
        phase <= PH_IDLE;
        cnt   <= '0;
      end else if (rise) begin
        case (phase)
          PH_IDLE: if (w_di) begin
            phase <= PH_CMD;
            cnt   <= CNT_W'(CMD_W);
            cmd   <= '0;
          end
          PH_CMD: begin
            cmd <= cmd_nx;
            cnt <= cnt - 1'b1;
            if (last) begin
              if (cmd_nx == CMD_READ) begin
                phase <= PH_ADR;
                cnt   <= CNT_W'(ADDR_W);
                adr   <= '0;
              end else begin
                err   <= 1'b1;
                phase <= PH_IDLE;
                cnt   <= '0;
              end
            end
          end
          PH_ADR: begin
            adr <= rom_addr;
            cnt <= cnt - 1'b1;
            if (last) begin
              if (rom_hit) begin
                sh    <= rom_word;
                phase <= PH_DAT;
                cnt   <= CNT_W'(WORD_W);
              end else begin
                err   <= 1'b1;
                phase <= PH_IDLE;
                cnt   <= '0;
              end
            end
          end
          PH_DAT: begin
            sh  <= {sh[WORD_W-2:0], 1'b0};
            cnt <= cnt - 1'b1;
            if (last) phase <= PH_IDLE;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  // R3
  desel_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !w_sel) |=> (phase == PH_IDLE));

  // R2
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(phase) && $stable(cnt) && $stable(sh)));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R7
  dat_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DAT) |-> (cnt >= CNT_W'(1) && cnt <= CNT_W'(WORD_W)));
endmodule

// File: rtl/mw_access_reg.sv
module mw_access_reg
  import mw_rom_pkg::*;
#(
  parameter int REG_W = 8,
  parameter logic [REG_W-1:0] RST_VAL = 8'h12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             do_load,
  input  logic             do_val,
  input  logic             di_clear,
  output logic [REG_W-1:0] rd_data
);
  logic [REG_W-1:0] r;

  always_ff @(posedge clk) begin
    if (rst) begin
      r <= RST_VAL;
    end else if (wr_en) begin
      r         <= wr_data;
      r[DO_BIT] <= do_load ? do_val : r[DO_BIT];
      if (!wr_data[SEL_BIT] || di_clear) r[DI_BIT] <= 1'b0;
    end
  end

  assign rd_data = r;

  // R9
  di_clean_chk: assert property (@(posedge clk) disable iff (rst)
    di_clear |=> (r[DI_BIT] == 1'b0));

  // R3
  sel_low_di_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[SEL_BIT]) |=> (r[DI_BIT] == 1'b0));

  // R8
  do_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !do_load) |=> (r[DO_BIT] == $past(r[DO_BIT])));
endmodule

// File: rtl/mw_rom_responder.sv
module mw_rom_responder
  import mw_rom_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int MAC_BYTES = 6,
  parameter int ADDR_W    = 6,
  parameter int WORD_W    = 16,
  parameter logic [REG_W-1:0]  RST_VAL = 8'h12,
  parameter logic [ADDR_W-1:0] BASE    = 6'hA
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [REG_W-1:0]       wr_data,
  input  logic [8*MAC_BYTES-1:0] station_addr,
  output logic [REG_W-1:0]       rd_data,
  output logic                   err_flag
);
  logic              rom_hit;
  logic [WORD_W-1:0] rom_word;
  logic [ADDR_W-1:0] rom_addr;
  logic              do_load;
  logic              do_val;
  logic              di_clear;

  mw_word_lookup #(
    .MAC_BYTES(MAC_BYTES), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .BASE(BASE)
  ) lookup_i (
    .station_addr(station_addr),
    .addr(rom_addr),
    .hit(rom_hit),
    .word(rom_word)
  );

  mw_serial_engine #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) engine_i (
    .clk(clk),
    .rst(rst),
    .wr_en(wr_en),
    .w_sel(wr_data[SEL_BIT]),
    .w_clk(wr_data[CLK_BIT]),
    .w_di(wr_data[DI_BIT]),
    .rom_hit(rom_hit),
    .rom_word(rom_word),
    .rom_addr(rom_addr),
    .do_load(do_load),
    .do_val(do_val),
    .di_clear(di_clear),
    .err(err_flag)
  );

  mw_access_reg #(
    .REG_W(REG_W), .RST_VAL(RST_VAL)
  ) reg_i (
    .clk(clk),
    .rst(rst),
    .wr_en(wr_en),
    .wr_data(wr_data),
    .do_load(do_load),
    .do_val(do_val),
    .di_clear(di_clear),
    .rd_data(rd_data)
  );
endmodule

// File: tb/mw_rom_responder_tb_top.sv
module mw_rom_responder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h0;
  logic [47:0] station_addr = 48'h0;
  logic [7:0]  rd_data;
  logic        err_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [3:0] up = 4'h0;

  always #5 clk = ~clk;

  mw_rom_responder dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .station_addr(station_addr), .rd_data(rd_data), .err_flag(err_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [47:0] mac, input logic [5:0] a);
    case (a)
      6'hA: exp_word = {mac[47:40], mac[39:32]};
      6'hB: exp_word = {mac[31:24], mac[23:16]};
      default: exp_word = {mac[15:8], mac[7:0]};
    endcase
  endfunction

  function automatic logic [7:0] mk(input bit sel, input bit ck, input bit di);
    mk = {up, sel, ck, 1'b0, di};
  endfunction

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bit_in(input bit b, input bit dup);
    wr(mk(1, 0, b));
    wr(mk(1, 1, b));
    if (dup) wr(mk(1, 1, b));
  endtask

  // Full read: leading zeros, start, read command, address, 16 data bits.
  task automatic rd_word(input logic [5:0] a, input int lead, input bit dup, input bit poke,
                         output logic [15:0] w, output logic di_after, output bit do_ok);
    logic cur;
    w = '0;
    do_ok = 1;
    for (int i = 0; i < lead; i++) bit_in(0, dup);
    bit_in(1, dup);
    bit_in(1, dup);
    bit_in(0, dup);
    for (int i = 5; i >= 0; i--) bit_in(a[i], dup);
    di_after = rd_data[0];
    cur = rd_data[1];
    for (int i = 0; i < 16; i++) begin
      wr(mk(1, 0, 0) | (poke ? {6'b0, ~cur, 1'b0} : 8'h0));
      if (rd_data[1] !== cur) do_ok = 0;
      wr(mk(1, 1, 0));
      if (dup) wr(mk(1, 1, 0));
      cur = rd_data[1];
      w = {w[14:0], rd_data[1]};
    end
  endtask

  task automatic bad_cmd(input logic [1:0] op);
    bit_in(1, 0);
    bit_in(op[1], 0);
    bit_in(op[0], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic di_a;
    bit dok;
    void'($urandom(32'd1357));
    station_addr = 48'hA1B2_C3D4_E5F6;
    do_reset();
    @(negedge clk);
    // R1
    chk(rd_data == 8'h12, "R1 reset value", rd_data, 8'h12);
    chk(err_flag == 1'b0, "R1 reset err", err_flag, 0);

    // R6 R7: each populated word
    for (int k = 0; k < 3; k++) begin
      rd_word(6'hA + 6'(k), 0, 0, 0, w, di_a, dok);
      chk(w == exp_word(station_addr, 6'hA + 6'(k)), "R6 R7 word map", w, exp_word(station_addr, 6'hA + 6'(k)));
    end

    // R7: extra edge after 16th bit leaves data-out
    begin
      logic last_do;
      last_do = rd_data[1];
      bit_in(0, 0);
      chk(rd_data[1] == last_do, "R7 idle after word", rd_data[1], last_do);
    end

    // R9: address 0xB ends with data-in 1, must read back 0
    rd_word(6'hB, 0, 0, 0, w, di_a, dok);
    chk(di_a == 1'b0, "R9 data-in cleared", di_a, 0);

    // R2: repeated clock-high writes do not advance; R4 leading zeros
    rd_word(6'hC, 3, 1, 0, w, di_a, dok);
    chk(w == exp_word(station_addr, 6'hC), "R2 R4 level vs edge", w, exp_word(station_addr, 6'hC));

    // R8: data-out forced opposite on writes is kept; upper bits stored
    up = 4'h9;
    rd_word(6'hA, 1, 0, 1, w, di_a, dok);
    chk(dok, "R8 data-out read-only", dok, 1);
    chk(w == exp_word(station_addr, 6'hA), "R8 word intact", w, exp_word(station_addr, 6'hA));
    chk(rd_data[7:4] == 4'h9, "R8 other bits written", rd_data[7:4], 4'h9);
    up = 4'h0;

    // R3: abort mid-address, data-in clears, then clean read
    bit_in(1, 0); bit_in(1, 0); bit_in(0, 0);
    bit_in(0, 0); bit_in(0, 0); bit_in(1, 0);
    wr(mk(0, 0, 1));
    chk(rd_data[0] == 1'b0, "R3 data-in clear on deselect", rd_data[0], 0);
    rd_word(6'hB, 0, 0, 0, w, di_a, dok);
    chk(w == exp_word(station_addr, 6'hB), "R3 read after abort", w, exp_word(station_addr, 6'hB));
    chk(err_flag == 1'b0, "R3 no error", err_flag, 0);

    // R5: bad commands
    bad_cmd(2'b11);
    chk(err_flag == 1'b1, "R5 bad command err", err_flag, 1);
    rd_word(6'hC, 0, 0, 0, w, di_a, dok);
    chk(w == exp_word(station_addr, 6'hC), "R5 idle after bad command", w, exp_word(station_addr, 6'hC));
    // R10
    chk(err_flag == 1'b1, "R10 sticky err", err_flag, 1);

    do_reset();
    @(negedge clk);
    bad_cmd(2'b01);
    chk(err_flag == 1'b1, "R5 write command err", err_flag, 1);

    // R6: unpopulated address
    do_reset();
    @(negedge clk);
    chk(err_flag == 1'b0, "R1 err cleared by reset", err_flag, 0);
    bit_in(1, 0); bit_in(1, 0); bit_in(0, 0);
    for (int i = 5; i >= 0; i--) bit_in(1'(6'h0D >> i), 0);
    chk(err_flag == 1'b1, "R6 bad address err", err_flag, 1);
    rd_word(6'hA, 0, 0, 0, w, di_a, dok);
    chk(w == exp_word(station_addr, 6'hA), "R6 idle after bad address", w, exp_word(station_addr, 6'hA));

    // Random mix
    for (int t = 0; t < 30; t++) begin
      logic [5:0] a;
      station_addr = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      a = 6'hA + 6'($urandom_range(0, 2));
      up = 4'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        bit_in(1, 0); bit_in(1, 0); bit_in(0, 0); bit_in(0, 0);
        wr(mk(0, 1, 1));
      end
      rd_word(a, $urandom_range(0, 2), 1'($urandom), 1'($urandom), w, di_a, dok);
      chk(w == exp_word(station_addr, a) && dok, "R7 random read", w, exp_word(station_addr, a));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule